// File: doc/BRIEF.md
# CEC Bit-Level Transmitter with Arbitration

This block puts one consumer-electronics-control message of 1 to 16 bytes onto a single-wire open-drain bus. It pulls the wire low through an active-high `drive_low` output and watches the resolved wire level on `line_in`. All bus timing is counted in microseconds, and each microsecond is one pulse of `tick`. The host loads the message bytes, the byte count, a broadcast flag and a signal-free count, then strobes `start`. When the attempt ends, the block returns a one-cycle `done` pulse together with a two-bit status.

After a request is accepted, the block waits until the wire has been high for long enough. It then sends a start bit and ten slots per byte: eight data bits with the most significant bit first, an end-of-message bit, and an acknowledge slot that it sends as a 1. In the initiator bits and in each acknowledge slot, whenever it sends a 1 it samples the wire. This is how it detects lost arbitration, reads the follower's acknowledge, and notices another device holding the wire low to flag an error.

Top module: `cec_bit_tx`

## Requirements
- R1: After reset `drive_low`, `busy` and `done` are 0. Whenever `busy` is 0, `drive_low` is 0.
- R2: The start bit drives the wire low for START_LOW_US ticks (3700 by default). The next falling edge follows START_TOTAL_US ticks (4500) after the start of the start bit.
- R3: A data 0 drives the wire low for ZERO_LOW_US ticks (1500) and a data 1 for ONE_LOW_US ticks (600). Falling edges of consecutive bits are BIT_TOTAL_US ticks (2400) apart.
- R4: Byte i is taken from `msg_data[8*i+7:8*i]`, and bytes go out in index order. Each byte is sent as 10 slots: its data bits from bit 7 down to bit 0, then an end-of-message bit that is 1 only on byte `msg_len-1`, then an acknowledge slot sent as 1.
- R5: The start bit begins only after the wire has been high without a break for at least (`free_bits`+1)×BIT_TOTAL_US ticks. A low level at any point restarts that count, and the request stays pending.
- R6: If the wire reads low SAMPLE_US ticks (850) after the falling edge of a 1 in the first four bits of byte 0, the block reports status 2 (arbitration lost) and sends nothing more.
- R7: At the acknowledge sample, a low wire acknowledges a directed message (`broadcast`=0) and a high wire acknowledges a broadcast. When the last byte is acknowledged, status 0 is reported at the end of its acknowledge slot.
- R8: If an acknowledge is missing, the block finishes that slot, reports status 1 (NACK) at the end of it, and sends no further byte.
- R9: If the wire is still low at the end of a sampled 1-bit slot, the block reports status 3 (low-drive error). `busy` then stays 1 until the wire reads high.
- R10: `done` is high for exactly one cycle per accepted request, and `status` is valid while `done` is high. `busy` falls in the same cycle that `done` rises, except for status 3.
- R11: `start` has no effect while `busy` is 1, or when `msg_len` is 0 or greater than MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per microsecond |
| line_in | input | 1 | Sampled wire level, 1 = high |
| drive_low | output | 1 | 1 pulls the wire low, 0 releases it |
| start | input | 1 | Request strobe |
| msg_data | input | MAX_BYTES*8 | Message bytes, byte i at bits 8i+7..8i |
| msg_len | input | LEN_W | Number of bytes, 1..MAX_BYTES |
| broadcast | input | 1 | Inverts the acknowledge sense |
| free_bits | input | SFT_W | Required idle time in whole bit periods, minus one |
| busy | output | 1 | A request is pending or in progress |
| done | output | 1 | One-cycle end-of-attempt pulse |
| status | output | 2 | 0 OK, 1 NACK, 2 arbitration lost, 3 low-drive error |

## Verification
The hardest conditions to create are those in which another party has to touch the wire at a precise time within a slot: a competing initiator during a sampled initiator bit, a follower acknowledge or broadcast reject, and an error pull that lasts past the end of a slot. The bench contains a reactive bus model. It counts the falling edges the block produces and, in chosen slots, pulls the wire low from that edge for a set number of ticks: 30 to cover the sample point, or 80 to cover the end of the slot. The free-time rule is tested by holding the wire low while a request is pending and then breaking the idle interval partway through the count.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

    typedef enum logic [1:0] {
        TX_OK        = 2'd0,
        TX_NACK      = 2'd1,
        TX_ARB_LOST  = 2'd2,
        TX_LOW_DRIVE = 2'd3
    } tx_status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PEND,
        PH_SB_LOW,
        PH_SB_HIGH,
        PH_BIT,
        PH_RECOVER
    } tx_phase_e;

    localparam int SLOTS_PER_BYTE = 10;
    localparam int EOM_SLOT       = 8;
    localparam int ACK_SLOT       = 9;
    localparam int INIT_BITS      = 4;

    typedef struct packed {
        logic value;    // level being sent in this slot
        logic sampled;  // wire is read during this slot
        logic is_ack;   // acknowledge slot
        logic last;     // slot belongs to the final byte
    } slot_info_t;

    function automatic logic ack_seen(input logic bcast, input logic wire_hi);
        return bcast ? wire_hi : !wire_hi;
    endfunction

endpackage

// File: rtl/cec_tx_usclock.sv
module cec_tx_usclock #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] us
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            us <= '0;
        else if (tick && (us != {W{1'b1}}))
            us <= us + 1'b1;
    end
endmodule

// File: rtl/cec_tx_freewatch.sv
module cec_tx_freewatch #(
    parameter int BIT_US = 2400,
    parameter int SFT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             line_in,
    input  logic [SFT_W-1:0] free_bits,
    output logic             free_ok
);
    localparam int LIMIT = BIT_US * (2 ** SFT_W);
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    logic [CW-1:0] high_cnt;
    logic [CW-1:0] need;

    always_ff @(posedge clk) begin
        if (rst || !line_in)
            high_cnt <= '0;
        else if (tick && (high_cnt != CAP))
            high_cnt <= high_cnt + 1'b1;
    end

    assign need    = CW'((32'(free_bits) + 32'd1) * 32'(BIT_US));
    assign free_ok = (high_cnt >= need);

    assert_low_clears_R5: assert property (@(posedge clk) disable iff (rst)
        !line_in |=> !free_ok);
endmodule

// File: rtl/cec_tx_slotgen.sv
module cec_tx_slotgen
    import cec_tx_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    parameter int BYTE_W    = 4,
    parameter int LEN_W     = 5
) (
    input  logic [MAX_BYTES*8-1:0] msg,
    input  logic [LEN_W-1:0]       len,
    input  logic [BYTE_W-1:0]      byte_idx,
    input  logic [3:0]             slot,
    output slot_info_t             info
);
    logic [7:0] bytes [MAX_BYTES];
    logic [7:0] cur_byte;
    logic [2:0] bsel;
    logic       is_last;
    logic       val;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_unpack
        assign bytes[g] = msg[g*8 +: 8];
    end

    assign cur_byte = bytes[byte_idx];
    assign bsel     = 3'(4'd7 - slot);
    assign is_last  = ((LEN_W'(byte_idx) + LEN_W'(1)) == len);

    always_comb begin
        if (slot < 4'(EOM_SLOT))
            val = cur_byte[bsel];
        else if (slot == 4'(EOM_SLOT))
            val = is_last;
        else
            val = 1'b1;
    end

    assign info.value   = val;
    assign info.is_ack  = (slot == 4'(ACK_SLOT));
    assign info.last    = is_last;
    assign info.sampled = val && (((byte_idx == '0) && (slot < 4'(INIT_BITS)))
                                  || (slot == 4'(ACK_SLOT)));
endmodule

// File: rtl/cec_bit_tx.sv
module cec_bit_tx
    import cec_tx_pkg::*;
#(
    parameter int MAX_BYTES      = 16,
    parameter int SFT_W          = 4,
    parameter int START_LOW_US   = 3700,
    parameter int START_TOTAL_US = 4500,
    parameter int BIT_TOTAL_US   = 2400,
    parameter int ZERO_LOW_US    = 1500,
    parameter int ONE_LOW_US     = 600,
    parameter int SAMPLE_US      = 850,
    localparam int LEN_W         = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   line_in,
    output logic                   drive_low,
    input  logic                   start,
    input  logic [MAX_BYTES*8-1:0] msg_data,
    input  logic [LEN_W-1:0]       msg_len,
    input  logic                   broadcast,
    input  logic [SFT_W-1:0]       free_bits,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             status
);
    localparam int BYTE_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int US_MAX = (START_TOTAL_US > BIT_TOTAL_US) ? START_TOTAL_US : BIT_TOTAL_US;
    localparam int US_W   = $clog2(US_MAX + 1);

    localparam logic [US_W-1:0] END_SB_LOW  = US_W'(START_LOW_US - 1);
    localparam logic [US_W-1:0] END_SB_HIGH = US_W'(START_TOTAL_US - START_LOW_US - 1);
    localparam logic [US_W-1:0] END_BIT     = US_W'(BIT_TOTAL_US - 1);
    localparam logic [US_W-1:0] END_SAMPLE  = US_W'(SAMPLE_US - 1);
    localparam logic [US_W-1:0] LOW_ZERO    = US_W'(ZERO_LOW_US);
    localparam logic [US_W-1:0] LOW_ONE     = US_W'(ONE_LOW_US);

    tx_phase_e              ph, ph_n;
    tx_status_e             stat_q, fin_code;
    logic [MAX_BYTES*8-1:0] msg_q;
    logic [LEN_W-1:0]       len_q;
    logic                   bc_q;
    logic [SFT_W-1:0]       sft_q;
    logic [BYTE_W-1:0]      byte_q, byte_n;
    logic [3:0]             slot_q, slot_n;
    logic                   nack_q, nack_n;
    logic                   done_q;
    logic                   fin, us_clr, load, accept;
    logic [US_W-1:0]        us;
    logic                   free_ok;
    slot_info_t             cur;
    logic                   hit_sb_low, hit_sb_high, hit_bit, hit_sample;

    cec_tx_usclock #(.W(US_W)) u_clock (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .clear(us_clr),
        .us   (us)
    );

    cec_tx_freewatch #(.BIT_US(BIT_TOTAL_US), .SFT_W(SFT_W)) u_free (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .line_in  (line_in),
        .free_bits(sft_q),
        .free_ok  (free_ok)
    );

    cec_tx_slotgen #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_slot (
        .msg     (msg_q),
        .len     (len_q),
        .byte_idx(byte_q),
        .slot    (slot_q),
        .info    (cur)
    );

    assign hit_sb_low  = tick && (us == END_SB_LOW);
    assign hit_sb_high = tick && (us == END_SB_HIGH);
    assign hit_bit     = tick && (us == END_BIT);
    assign hit_sample  = tick && (us == END_SAMPLE);

    assign accept = start && (msg_len != '0) && (msg_len <= LEN_W'(MAX_BYTES));

    always_comb begin
        ph_n     = ph;
        byte_n   = byte_q;
        slot_n   = slot_q;
        nack_n   = nack_q;
        fin      = 1'b0;
        fin_code = TX_OK;
        us_clr   = 1'b0;
        load     = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                if (accept) begin
                    load = 1'b1;
                    ph_n = PH_PEND;
                end
            end
            PH_PEND: begin
                if (free_ok && line_in) begin
                    ph_n   = PH_SB_LOW;
                    us_clr = 1'b1;
                    nack_n = 1'b0;
                end
            end
            PH_SB_LOW: begin
                if (hit_sb_low) begin
                    ph_n   = PH_SB_HIGH;
                    us_clr = 1'b1;
                end
            end
            PH_SB_HIGH: begin
                if (hit_sb_high) begin
                    ph_n   = PH_BIT;
                    us_clr = 1'b1;
                    byte_n = '0;
                    slot_n = '0;
                end
            end
            PH_BIT: begin
                if (hit_sample && cur.sampled) begin
                    if (!cur.is_ack && !line_in) begin
                        fin      = 1'b1;
                        fin_code = TX_ARB_LOST;
                        ph_n     = PH_IDLE;
                    end else if (cur.is_ack && !ack_seen(bc_q, line_in)) begin
                        nack_n = 1'b1;
                    end
                end else if (hit_bit) begin
                    if (cur.sampled && !line_in) begin
                        fin      = 1'b1;
                        fin_code = TX_LOW_DRIVE;
                        ph_n     = PH_RECOVER;
                    end else if (nack_q) begin
                        fin      = 1'b1;
                        fin_code = TX_NACK;
                        ph_n     = PH_IDLE;
                    end else if (cur.is_ack && cur.last) begin
                        fin      = 1'b1;
                        fin_code = TX_OK;
                        ph_n     = PH_IDLE;
                    end else begin
                        us_clr = 1'b1;
                        if (cur.is_ack) begin
                            slot_n = '0;
                            byte_n = byte_q + 1'b1;
                        end else begin
                            slot_n = slot_q + 1'b1;
                        end
                    end
                end
            end
            PH_RECOVER: begin
                if (line_in)
                    ph_n = PH_IDLE;
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            stat_q <= TX_OK;
            msg_q  <= '0;
            len_q  <= '0;
            bc_q   <= 1'b0;
            sft_q  <= '0;
            byte_q <= '0;
            slot_q <= '0;
            nack_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ph     <= ph_n;
            byte_q <= byte_n;
            slot_q <= slot_n;
            nack_q <= nack_n;
            done_q <= fin;
            if (fin)
                stat_q <= fin_code;
            if (load) begin
                msg_q <= msg_data;
                len_q <= msg_len;
                bc_q  <= broadcast;
                sft_q <= free_bits;
            end
        end
    end

    assign drive_low = (ph == PH_SB_LOW)
                    || ((ph == PH_BIT) && (us < (cur.value ? LOW_ONE : LOW_ZERO)));
    assign busy   = (ph != PH_IDLE);
    assign done   = done_q;
    assign status = stat_q;

    assert_released_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !drive_low);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_after_free_R5: assert property (@(posedge clk) disable iff (rst)
        ((ph == PH_SB_LOW) && ($past(ph) == PH_PEND)) |-> $past(free_ok));

    assert_arb_in_initiator_R6: assert property (@(posedge clk) disable iff (rst)
        (done && (status == 2'd2)) |-> ((byte_q == '0) && (slot_q < 4'(INIT_BITS))));

    assert_nack_at_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (done && (status == 2'd1)) |-> (slot_q == 4'(ACK_SLOT)));

    assert_ok_on_last_R7: assert property (@(posedge clk) disable iff (rst)
        (done && (status == 2'd0)) |->
            ((slot_q == 4'(ACK_SLOT)) && ((LEN_W'(byte_q) + LEN_W'(1)) == len_q)));

    assert_lowdrive_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && (status == 2'd3)) |-> (busy && !drive_low));
endmodule

// File: tb/cec_bit_tx_test.sv
module cec_bit_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB  = 16;
    localparam int SBL   = 74;
    localparam int SBT   = 90;
    localparam int BITT  = 48;
    localparam int ZLOW  = 30;
    localparam int OLOW  = 12;
    localparam int SMP   = 17;
    localparam int NVEC  = 8;

    typedef struct packed {
        logic [4:0]  len;
        logic        bc;
        logic [3:0]  sft;
        logic [4:0]  nack_b;
        logic [4:0]  arb_s;
        logic [7:0]  ldrv_s;
        logic [23:0] data;
        logic [1:0]  st;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{5'd1, 1'b0, 4'd0, 5'd31, 5'd31, 8'd255, 24'h000040, 2'd0},
        '{5'd3, 1'b0, 4'd2, 5'd31, 5'd31, 8'd255, 24'h5A3410, 2'd0},
        '{5'd2, 1'b1, 4'd1, 5'd31, 5'd31, 8'd255, 24'h00364F, 2'd0},
        '{5'd3, 1'b0, 4'd0, 5'd1,  5'd31, 8'd255, 24'h221144, 2'd1},
        '{5'd2, 1'b1, 4'd0, 5'd0,  5'd31, 8'd255, 24'h0012F3, 2'd1},
        '{5'd1, 1'b0, 4'd0, 5'd31, 5'd2,  8'd255, 24'h0000F0, 2'd2},
        '{5'd2, 1'b0, 4'd0, 5'd31, 5'd0,  8'd255, 24'h00778F, 2'd2},
        '{5'd2, 1'b0, 4'd0, 5'd31, 5'd31, 8'd9,   24'h005533, 2'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic start = 1'b0;
    logic bcast = 1'b0;
    logic [MAXB*8-1:0] msg = '0;
    logic [4:0] len = '0;
    logic [3:0] sft = '0;
    logic pull_low = 1'b0;
    logic man_low = 1'b0;
    logic line_in;
    logic drive_low, busy, done;
    logic [1:0] status;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // bus model state
    int  lw = 0, per = 0, rise_n = 0, cap_n = 0, pull_cnt = 0, done_cnt = 0;
    int  bad_w = 0, bad_p = 0;
    logic pd = 1'b0;
    logic cap_bits [200];
    logic cur_bc = 1'b0;
    int  cur_nack = 31, cur_arb = 31, cur_ldrv = 255;

    assign line_in = !(drive_low || pull_low || man_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    cec_bit_tx #(
        .MAX_BYTES(MAXB), .SFT_W(4),
        .START_LOW_US(SBL), .START_TOTAL_US(SBT), .BIT_TOTAL_US(BITT),
        .ZERO_LOW_US(ZLOW), .ONE_LOW_US(OLOW), .SAMPLE_US(SMP)
    ) uut (
        .clk(clk), .rst(rst), .tick(tick), .line_in(line_in), .drive_low(drive_low),
        .start(start), .msg_data(msg), .msg_len(len), .broadcast(bcast),
        .free_bits(sft), .busy(busy), .done(done), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reactive bus: decodes pulses, acknowledges, competes, flags errors
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (drive_low) lw++;
        if (pd && !drive_low) begin
            if (rise_n == 1) begin
                if (lw != SBL) bad_w++;
            end else if (lw == OLOW || lw == ZLOW) begin
                if (cap_n < 200) cap_bits[cap_n] = (lw == OLOW);
                cap_n++;
            end else begin
                bad_w++;
            end
            lw = 0;
        end
        if (!pd && drive_low) begin
            if (rise_n == 1 && per != SBT) bad_p++;
            if (rise_n > 1 && per != BITT) bad_p++;
            per = 0;
            if (rise_n >= 1) begin
                int k;
                k = rise_n - 1;
                if (k % 10 == 9) begin
                    if (!cur_bc && (k / 10) < cur_nack) pull_cnt = ZLOW;
                    if (cur_bc && (k / 10) == cur_nack) pull_cnt = ZLOW;
                end
                if (k == cur_arb) pull_cnt = ZLOW;
                if (k == cur_ldrv) pull_cnt = 80;
            end
            rise_n++;
        end
        per++;
        pd = drive_low;
        pull_low = (pull_cnt > 0);
        if (pull_cnt > 0) pull_cnt--;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic clear_model(input logic b, input int nk, input int ar, input int ld);
        rise_n = 0; cap_n = 0; done_cnt = 0; pull_cnt = 0; lw = 0; per = 0;
        cur_bc = b; cur_nack = nk; cur_arb = ar; cur_ldrv = ld;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok, output logic [1:0] st, output logic bz);
        ok = 0; st = 0; bz = 0;
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            if (done) begin ok = 1; st = status; bz = busy; break; end
        end
    endtask

    function automatic logic exp_bit(input vec_t v, input int k);
        int b, s;
        b = k / 10; s = k % 10;
        if (s < 8) return v.data[b*8 + 7 - s];
        if (s == 8) return (b == int'(v.len) - 1);
        return 1'b1;
    endfunction

    task automatic run_vec(input int i);
        vec_t v;
        bit ok;
        logic [1:0] st;
        logic bz;
        int exp_n, mism;
        string tag;
        v = VECS[i];
        @(negedge clk);
        clear_model(v.bc, int'(v.nack_b), int'(v.arb_s), int'(v.ldrv_s));
        msg = '0; msg[23:0] = v.data; len = v.len; bcast = v.bc; sft = v.sft;
        pulse_start();
        wait_done(ok, st, bz);
        chk(ok, "R10 done seen", int'(ok), 1);
        case (v.st)
            2'd0: begin tag = "R7";  exp_n = int'(v.len) * 10; end
            2'd1: begin tag = "R8";  exp_n = (int'(v.nack_b) + 1) * 10; end
            2'd2: begin tag = "R6";  exp_n = int'(v.arb_s) + 1; end
            default: begin tag = "R9"; exp_n = int'(v.ldrv_s) + 1; end
        endcase
        chk(st == v.st, {tag, " status"}, int'(st), int'(v.st));
        chk(bz == (v.st == 2'd3), "R10 busy at done", int'(bz), int'(v.st == 2'd3));
        repeat (150) @(negedge clk);
        chk(cap_n == exp_n, {tag, " R4 slot count"}, cap_n, exp_n);
        mism = 0;
        for (int k = 0; k < cap_n && k < 200; k++)
            if (cap_bits[k] !== exp_bit(v, k)) mism++;
        chk(mism == 0, "R4 slot values", mism, 0);
        chk(done_cnt == 1, "R10 done width", done_cnt, 1);
        chk(!busy && !drive_low, "R9 R1 released after end", int'(busy), 0);
    endtask

    initial begin
        bit ok;
        logic [1:0] st;
        logic bz;
        int n;
        repeat (3) @(negedge clk);
        chk(!drive_low && !busy && !done, "R1 reset outputs", int'({drive_low, busy, done}), 0);
        rst = 1'b0;
        repeat (200) @(negedge clk);
        chk(!drive_low && !busy, "R1 idle after reset", int'({drive_low, busy}), 0);

        for (int i = 0; i < NVEC; i++) run_vec(i);
        chk(bad_w == 0, "R2 R3 low widths", bad_w, 0);
        chk(bad_p == 0, "R2 R3 periods", bad_p, 0);

        // R11: zero length ignored
        @(negedge clk);
        clear_model(1'b0, 31, 31, 255);
        len = 5'd0;
        pulse_start();
        repeat (300) @(negedge clk);
        chk(!busy && rise_n == 0, "R11 zero length ignored", rise_n, 0);

        // R5: pending while wire low, exact free interval after release
        clear_model(1'b0, 31, 31, 255);
        msg = '0; msg[7:0] = 8'h40; len = 5'd1; sft = 4'd1; bcast = 1'b0;
        man_low = 1'b1;
        pulse_start();
        repeat (200) @(negedge clk);
        chk(busy && rise_n == 0, "R5 held while low", rise_n, 0);
        man_low = 1'b0;
        n = 0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk); n++;
            if (drive_low) break;
        end
        chk(n >= 2*BITT && n <= 2*BITT + 3, "R5 free interval", n, 2*BITT + 1);
        wait_done(ok, st, bz);
        chk(ok && st == 2'd0, "R5 transfer after wait", int'(st), 0);
        repeat (20) @(negedge clk);

        // R5: break in the idle interval restarts the count
        clear_model(1'b0, 31, 31, 255);
        man_low = 1'b1;
        pulse_start();
        repeat (5) @(negedge clk);
        man_low = 1'b0;
        repeat (60) @(negedge clk);
        chk(rise_n == 0, "R5 no start in partial interval", rise_n, 0);
        man_low = 1'b1;
        repeat (5) @(negedge clk);
        man_low = 1'b0;
        n = 0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk); n++;
            if (drive_low) break;
        end
        chk(n >= 2*BITT && n <= 2*BITT + 3, "R5 count restarted", n, 2*BITT + 1);
        wait_done(ok, st, bz);
        repeat (20) @(negedge clk);

        // R11: start while busy ignored
        clear_model(1'b0, 31, 31, 255);
        msg = '0; msg[15:0] = 16'h3C21; len = 5'd2; sft = 4'd0;
        pulse_start();
        repeat (300) @(negedge clk);
        msg[7:0] = 8'hFF; len = 5'd1;
        pulse_start();
        wait_done(ok, st, bz);
        repeat (50) @(negedge clk);
        chk(ok && st == 2'd0, "R11 status unchanged", int'(st), 0);
        chk(cap_n == 20, "R11 length kept", cap_n, 20);
        chk(done_cnt == 1, "R11 single done", done_cnt, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule